// File: doc/BRIEF.md
# Extended-Precision Accumulator ALU

This block is the two-operand arithmetic and logic stage of a DSP datapath. It holds a small file of 36-bit accumulators (four guard bits above a 32-bit word). Each operation takes a source accumulator and a second operand, and the second operand comes from one of four places: a second accumulator, a 32-bit product register, a 16-bit immediate placed in the upper half of the 32-bit word, or a 16-bit immediate placed in the lower half. The block supports add, subtract, AND, OR and XOR. The result goes either to a destination accumulator, which is chosen independently of the sources, or is discarded in compare/test mode, where only the condition flags change.

The second operand is shaped before the operation. A product is sign-extended into the guard bits. An upper-half immediate is sign-extended above and zero-filled below, except for AND, which fills the lower half with ones. A lower-half immediate gets zeros above, except for AND, which gets ones above. Because of this shaping, an upper-half operation followed by a lower-half operation gives the same result as one operation with a 32-bit immediate. Register operands finish in one cycle. Immediate operands take two cycles, and `busy` marks the extra cycle. A load port writes accumulators directly, and a combinational read port shows any accumulator.

Top module: `acc_alu`

## Requirements
- R1: With `op_bsrc`=0 the second operand is accumulator `op_tsel`, used as a full 36-bit value. An accepted operation writes the 36-bit result to `op_dst` at the issuing edge, and `done` is high for the cycle after that edge.
- R2: With `op_bsrc`=1 the second operand is `prod`, sign-extended from bit 31 into bits 35..32.
- R3: With `op_bsrc`=2 the second operand has `op_imm` in bits 31..16, its bit 15 copied into bits 35..32, and bits 15..0 set to zero for add, subtract, OR and XOR, or set to ones for AND.
- R4: With `op_bsrc`=3 the second operand has `op_imm` in bits 15..0, and bits 35..16 set to zero for add, subtract, OR and XOR, or set to ones for AND.
- R5: An immediate operation (`op_bsrc` bit 1 set) raises `busy` for exactly one cycle after it issues. Its accumulator and flag updates happen at the following edge, and `done` is high for the cycle after that. Any `op_valid` seen while `busy` is high is ignored.
- R6: With `op_cmp`=1 the flags are updated and no accumulator is written.
- R7: `flag_n` equals result bit 35. `flag_z` is set exactly when all 36 result bits are zero.
- R8: `flag_v32` is set when result bits 35..31 are not all equal, for every operation.
- R9: `flag_v36` is set when an add or subtract overflows the signed 36-bit range. It is cleared by AND, OR and XOR.
- R10: When `ld_en` is high, `ld_data` is written to accumulator `ld_sel` at the edge. If an ALU write to the same accumulator completes at that edge, the ALU result is kept instead.
- R11: Opcodes are 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR. Codes 5 to 7 are ignored: no accumulator, flag, `busy` or `done` change.
- R12: An upper-half immediate operation with `op_imm`=H, followed by a lower-half one with `op_imm`=L, leaves the same accumulator value as the operation with the 32-bit immediate {H,L} sign-extended to 36 bits. This holds for add and for AND.
- R13: After reset, every accumulator reads zero, and all flags, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 3 | Operation select |
| op_src | input | 1 | Source accumulator index |
| op_tsel | input | 1 | Second accumulator index (when `op_bsrc`=0) |
| op_dst | input | 1 | Destination accumulator index |
| op_bsrc | input | 2 | Second operand source: 0 accumulator, 1 product, 2 upper immediate, 3 lower immediate |
| op_cmp | input | 1 | Flags-only mode |
| op_imm | input | 16 | Immediate value |
| prod | input | 32 | Product register value |
| ld_en | input | 1 | Accumulator load enable |
| ld_sel | input | 1 | Accumulator load index |
| ld_data | input | 36 | Accumulator load value |
| rd_sel | input | 1 | Read port index |
| rd_data | output | 36 | Read port value |
| busy | output | 1 | Immediate operation in progress |
| done | output | 1 | An operation completed at the previous edge |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v32 | output | 1 | 32-bit overflow flag |
| flag_v36 | output | 1 | 36-bit arithmetic overflow flag |

## Verification
Two events can hit the same accumulator at the same edge: an ALU write that completes (from a register operation or from the commit of an immediate) and a direct load through the load port. The bench forces this with directed cycles that point `ld_sel` at the destination of a completing operation, in both the one-cycle and the two-cycle case. Random traffic also asserts `ld_en` together with operations. A behavioural model, in which the ALU result wins, judges every cycle by reading back both accumulators and the flags. The second collision is a new request during `busy`. The model expects that request to be dropped, and the bench checks that it is.

// File: rtl/acc_alu_pkg.sv
// Package: shared encodings for the accumulator ALU.
// Assumes nothing beyond the widths fixed by the users of these types.
package acc_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        BS_ACC  = 2'd0,
        BS_PROD = 2'd1,
        BS_IMMH = 2'd2,
        BS_IMML = 2'd3
    } bsrc_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v32;
        logic v36;
    } alu_flags_t;

endpackage

// File: rtl/acc_alu_opfmt.sv
// Module: second-operand shaper. Widens the selected operand to the
// accumulator width: sign-extends products, aligns immediates to the upper or
// lower half, and picks the zero or one fill from the operation (ones for AND).
// Assumes PROD_W == 2*IMM_W and ACC_W > PROD_W.
module acc_alu_opfmt
    import acc_alu_pkg::*;
#(
    parameter int ACC_W  = 36,
    parameter int PROD_W = 32,
    parameter int IMM_W  = 16
) (
    input  bsrc_e              bsrc,
    input  logic               is_and,
    input  logic [ACC_W-1:0]   acc_t,
    input  logic [PROD_W-1:0]  prod,
    input  logic [IMM_W-1:0]   imm,
    output logic [ACC_W-1:0]   b_opnd
);
    localparam int GUARD_W = ACC_W - PROD_W;
    localparam int LOFILL_W = PROD_W - IMM_W;
    localparam int HIFILL_W = ACC_W - IMM_W;

    logic [LOFILL_W-1:0] lo_fill;
    logic [HIFILL_W-1:0] hi_fill;

    // fill patterns for the unused immediate bits
    always_comb begin
        lo_fill = {LOFILL_W{is_and}};
        hi_fill = {HIFILL_W{is_and}};
    end

    // select and widen the operand
    always_comb begin
        unique case (bsrc)
            BS_ACC:  b_opnd = acc_t;
            BS_PROD: b_opnd = {{GUARD_W{prod[PROD_W-1]}}, prod};
            BS_IMMH: b_opnd = {{GUARD_W{imm[IMM_W-1]}}, imm, lo_fill};
            default: b_opnd = {hi_fill, imm};
        endcase
    end

endmodule

// File: rtl/acc_alu_core.sv
// Module: combinational 36-bit arithmetic/logic stage with condition flags.
// Assumes a legal opcode; flags describe the full-width result.
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int ACC_W  = 36,
    parameter int PROD_W = 32
) (
    input  alu_op_e            op,
    input  logic [ACC_W-1:0]   a,
    input  logic [ACC_W-1:0]   b,
    output logic [ACC_W-1:0]   res,
    output alu_flags_t         flg
);
    localparam int MSB = ACC_W - 1;
    localparam int V32_LSB = PROD_W - 1;

    logic [ACC_W-1:0] sum, dif;
    logic [ACC_W-1-V32_LSB:0] top_bits;

    // both arithmetic results are formed in parallel
    always_comb begin
        sum = a + b;
        dif = a - b;
    end

    // result selection
    always_comb begin
        unique case (op)
            OP_ADD:  res = sum;
            OP_SUB:  res = dif;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            default: res = a ^ b;
        endcase
    end

    // flag derivation from result and operand signs
    always_comb begin
        top_bits = res[MSB:V32_LSB];
        flg.n    = res[MSB];
        flg.z    = ~|res;
        flg.v32  = ~((&top_bits) | ~(|top_bits));
        unique case (op)
            OP_ADD:  flg.v36 = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
            OP_SUB:  flg.v36 = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
            default: flg.v36 = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
// Module: accumulator ALU top. Holds the accumulator file and the flags,
// issues one- and two-cycle operations, and merges load-port writes.
// Assumes operation requests arriving during busy are dropped by design.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int ACC_W  = 36,
    parameter int PROD_W = 32,
    parameter int IMM_W  = 16,
    parameter int NACC   = 2,
    localparam int AW    = (NACC > 1) ? $clog2(NACC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [AW-1:0]     op_src,
    input  logic [AW-1:0]     op_tsel,
    input  logic [AW-1:0]     op_dst,
    input  logic [1:0]        op_bsrc,
    input  logic              op_cmp,
    input  logic [IMM_W-1:0]  op_imm,
    input  logic [PROD_W-1:0] prod,
    input  logic              ld_en,
    input  logic [AW-1:0]     ld_sel,
    input  logic [ACC_W-1:0]  ld_data,
    input  logic [AW-1:0]     rd_sel,
    output logic [ACC_W-1:0]  rd_data,
    output logic              busy,
    output logic              done,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v32,
    output logic              flag_v36
);
    logic [NACC-1:0][ACC_W-1:0] acc_q;
    alu_flags_t flags_q;
    logic busy_q, done_q;

    // staged result of a two-cycle immediate operation
    logic [ACC_W-1:0] stg_res;
    alu_flags_t       stg_flg;
    logic [AW-1:0]    stg_dst;
    logic             stg_cmp, stg_logic;

    alu_op_e          op_e;
    logic             op_legal, issue, imm_form, op_logic;
    logic [ACC_W-1:0] a_val, t_val, b_val, live_res;
    alu_flags_t       live_flg;

    // commit selection
    logic             commit_now, commit_wr, c_logic;
    logic [ACC_W-1:0] c_res;
    alu_flags_t       c_flg;
    logic [AW-1:0]    c_dst;

    // decode of the request
    always_comb begin
        op_e     = alu_op_e'(op_code);
        op_legal = (op_code <= 3'(OP_XOR));
        imm_form = op_bsrc[1];
        issue    = op_valid && !busy_q && op_legal;
        op_logic = (op_e == OP_AND) || (op_e == OP_OR) || (op_e == OP_XOR);
        a_val    = acc_q[op_src];
        t_val    = acc_q[op_tsel];
    end

    acc_alu_opfmt #(.ACC_W(ACC_W), .PROD_W(PROD_W), .IMM_W(IMM_W)) u_opfmt (
        .bsrc   (bsrc_e'(op_bsrc)),
        .is_and (op_e == OP_AND),
        .acc_t  (t_val),
        .prod   (prod),
        .imm    (op_imm),
        .b_opnd (b_val)
    );

    acc_alu_core #(.ACC_W(ACC_W), .PROD_W(PROD_W)) u_core (
        .op  (op_e),
        .a   (a_val),
        .b   (b_val),
        .res (live_res),
        .flg (live_flg)
    );

    // choose between a staged immediate result and a live register result
    always_comb begin
        commit_now = busy_q || (issue && !imm_form);
        if (busy_q) begin
            c_res   = stg_res;
            c_flg   = stg_flg;
            c_dst   = stg_dst;
            c_logic = stg_logic;
            commit_wr = !stg_cmp;
        end else begin
            c_res   = live_res;
            c_flg   = live_flg;
            c_dst   = op_dst;
            c_logic = op_logic;
            commit_wr = commit_now && !op_cmp;
        end
    end

    // sequencing: busy, done and the immediate stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            stg_res   <= '0;
            stg_flg   <= '0;
            stg_dst   <= '0;
            stg_cmp   <= 1'b0;
            stg_logic <= 1'b0;
        end else begin
            busy_q <= issue && imm_form;
            done_q <= commit_now;
            if (issue && imm_form) begin
                stg_res   <= live_res;
                stg_flg   <= live_flg;
                stg_dst   <= op_dst;
                stg_cmp   <= op_cmp;
                stg_logic <= op_logic;
            end
        end
    end

    // condition flags update on completion
    always_ff @(posedge clk) begin
        if (!rst_n)          flags_q <= '0;
        else if (commit_now) flags_q <= c_flg;
    end

    // accumulator file: ALU write has priority over the load port
    for (genvar gi = 0; gi < NACC; gi++) begin : g_acc
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc_q[gi] <= '0;
            else if (commit_wr && (c_dst == AW'(gi)))
                acc_q[gi] <= c_res;
            else if (ld_en && (ld_sel == AW'(gi)))
                acc_q[gi] <= ld_data;
        end
    end

    assign rd_data  = acc_q[rd_sel];
    assign busy     = busy_q;
    assign done     = done_q;
    assign flag_n   = flags_q.n;
    assign flag_z   = flags_q.z;
    assign flag_v32 = flags_q.v32;
    assign flag_v36 = flags_q.v36;

    // R5: the extra cycle of an immediate operation lasts exactly one cycle
    a_r5_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> !busy_q);

    // R5: completion follows the busy cycle
    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> done_q);

    // R6: compare/test completion leaves the accumulators untouched
    a_r6_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_now && !commit_wr && !ld_en) |=> $stable(acc_q));

    // R7: negative flag agrees with the written accumulator's sign bit
    a_r7_n_matches_acc: assert property (@(posedge clk) disable iff (!rst_n)
        commit_wr |=> (flags_q.n == acc_q[$past(c_dst)][ACC_W-1]));

    // R9: logical operations leave the 36-bit overflow clear
    a_r9_logic_no_v36: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_now && c_logic) |=> !flags_q.v36);

    // R11: illegal opcodes start nothing
    a_r11_bad_op_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy_q && !op_legal) |=> (!busy_q && !done_q));

endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic        op_src = 1'b0, op_tsel = 1'b0, op_dst = 1'b0;
    logic [1:0]  op_bsrc = '0;
    logic        op_cmp = 1'b0;
    logic [15:0] op_imm = '0;
    logic [31:0] prod = '0;
    logic        ld_en = 1'b0, ld_sel = 1'b0;
    logic [35:0] ld_data = '0;
    logic        rd_sel = 1'b0;
    logic [35:0] rd_data;
    logic        busy, done, flag_n, flag_z, flag_v32, flag_v36;

    always #10 clk = ~clk;

    acc_alu dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_src(op_src), .op_tsel(op_tsel), .op_dst(op_dst), .op_bsrc(op_bsrc),
        .op_cmp(op_cmp), .op_imm(op_imm), .prod(prod), .ld_en(ld_en),
        .ld_sel(ld_sel), .ld_data(ld_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .busy(busy), .done(done), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v32(flag_v32), .flag_v36(flag_v36)
    );

    int    vectors = 0;
    int    miscompares = 0;
    bit    finished = 0;
    string cur_req = "R13";

    // behavioural reference state
    logic [35:0] m_acc [2];
    logic [3:0]  m_flg;
    logic        m_busy, m_done;
    logic [35:0] p_res;
    logic [3:0]  p_flg;
    logic        p_dst, p_cmp;

    task automatic chk(string what, logic [35:0] act, logic [35:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // reference operation: operand shaping by rule, arithmetic on integers
    task automatic model_op(input logic [35:0] a, input logic [35:0] at,
                            output logic [35:0] r, output logic [3:0] f);
        logic [35:0] b;
        longint sa, sb, ex, sr;
        bit is_and = (op_code == 3'd2);
        case (op_bsrc)
            2'd0: b = at;
            2'd1: b = {{4{prod[31]}}, prod};
            2'd2: b = {{4{op_imm[15]}}, op_imm, is_and ? 16'hFFFF : 16'h0000};
            default: b = {is_and ? 20'hFFFFF : 20'h00000, op_imm};
        endcase
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ex = 0;
        case (op_code)
            3'd0: ex = sa + sb;
            3'd1: ex = sa - sb;
            3'd2: r = a & b;
            3'd3: r = a | b;
            default: r = a ^ b;
        endcase
        if (op_code <= 3'd1) r = ex[35:0];
        sr = longint'($signed(r));
        f[3] = r[35];
        f[2] = (r == 36'd0);
        f[1] = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        f[0] = (op_code <= 3'd1) &&
               ((ex > 64'sd34359738367) || (ex < -64'sd34359738368));
    endtask

    task automatic model_update();
        logic [35:0] r, cres;
        logic [3:0]  f;
        bit iss, commit, cw;
        logic cdst;
        if (!rst_n) begin
            m_acc[0] = '0; m_acc[1] = '0; m_flg = '0; m_busy = 0; m_done = 0;
            p_res = '0; p_flg = '0; p_dst = 0; p_cmp = 0;
            return;
        end
        iss = op_valid && !m_busy && (op_code <= 3'd4);
        commit = 0; cw = 0; cdst = 0; cres = '0;
        if (m_busy) begin
            commit = 1; cres = p_res; cdst = p_dst; cw = !p_cmp; m_flg = p_flg;
        end else if (iss) begin
            model_op(m_acc[op_src], m_acc[op_tsel], r, f);
            if (op_bsrc[1]) begin
                p_res = r; p_flg = f; p_dst = op_dst; p_cmp = op_cmp;
            end else begin
                commit = 1; cres = r; cdst = op_dst; cw = !op_cmp; m_flg = f;
            end
        end
        if (cw) m_acc[cdst] = cres;
        if (ld_en && !(cw && cdst == ld_sel)) m_acc[ld_sel] = ld_data;
        m_done = commit;
        m_busy = iss && op_bsrc[1];
    endtask

    task automatic compare();
        rd_sel = 1'b0; #1;
        chk("acc0", rd_data, m_acc[0]);
        rd_sel = 1'b1; #1;
        chk("acc1", rd_data, m_acc[1]);
        chk("busy", 36'(busy), 36'(m_busy));
        chk("done", 36'(done), 36'(m_done));
        chk("flags", 36'({flag_n, flag_z, flag_v32, flag_v36}), 36'(m_flg));
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        op_valid = 0; ld_en = 0;
    endtask

    task automatic issue_op(logic [2:0] code, logic s, logic t, logic d,
                            logic [1:0] bs, logic cmp, logic [15:0] im);
        op_valid = 1; op_code = code; op_src = s; op_tsel = t; op_dst = d;
        op_bsrc = bs; op_cmp = cmp; op_imm = im;
    endtask

    task automatic load(logic sel, logic [35:0] v);
        ld_en = 1; ld_sel = sel; ld_data = v;
    endtask

    initial begin
        longint exp_sum;
        logic [35:0] base;
        repeat (3) step();
        rst_n = 1;
        cur_req = "R13";
        step();

        // R1: acc + acc, full 36 bits including guard bits
        cur_req = "R1";
        load(0, 36'h8_0000_0003); step(); load(1, 36'h7_FFFF_FFFF); step(); idle();
        issue_op(3'd0, 0, 1, 1, 2'd0, 0, '0); step(); idle(); step();
        // R2: negative product sign-extended
        cur_req = "R2";
        prod = 32'h8000_0001; issue_op(3'd1, 0, 0, 0, 2'd1, 0, '0); step(); idle(); step();
        // R3: upper immediate, zero fill and ones fill
        cur_req = "R3";
        issue_op(3'd0, 1, 0, 0, 2'd2, 0, 16'hF00F); step(); idle(); step();
        issue_op(3'd2, 1, 0, 1, 2'd2, 0, 16'h1234); step(); idle(); step();
        // R4: lower immediate, zero fill and ones fill
        cur_req = "R4";
        issue_op(3'd3, 0, 0, 0, 2'd3, 0, 16'h00F0); step(); idle(); step();
        issue_op(3'd2, 0, 0, 1, 2'd3, 0, 16'h0F0F); step(); idle(); step();
        // R5: request during busy is dropped
        cur_req = "R5";
        issue_op(3'd4, 0, 0, 1, 2'd2, 0, 16'hAAAA); step();
        issue_op(3'd0, 0, 0, 0, 2'd0, 0, '0); step(); idle(); step();
        // R6: compare and test leave accumulators
        cur_req = "R6";
        issue_op(3'd1, 0, 1, 0, 2'd0, 1, '0); step();
        issue_op(3'd2, 1, 0, 1, 2'd3, 1, 16'h0000); step(); idle(); step();
        // R7: zero result
        cur_req = "R7";
        issue_op(3'd1, 0, 0, 1, 2'd0, 0, '0); step(); idle(); step();
        // R8 / R9: 32-bit then 36-bit overflow, then logical clears it
        cur_req = "R8";
        load(0, 36'h0_7FFF_FFFF); step(); idle();
        issue_op(3'd0, 0, 0, 1, 2'd3, 0, 16'h0001); step(); idle(); step();
        cur_req = "R9";
        load(0, 36'h7_FFFF_FFFF); step(); idle();
        issue_op(3'd0, 0, 0, 1, 2'd3, 0, 16'h0001); step(); idle(); step();
        issue_op(3'd3, 0, 0, 1, 2'd0, 0, '0); step(); idle(); step();
        // R10: load collides with completing ALU write (one- and two-cycle)
        cur_req = "R10";
        issue_op(3'd0, 0, 0, 1, 2'd0, 0, '0); load(1, 36'h1_2345_6789); step(); idle(); step();
        issue_op(3'd4, 0, 0, 0, 2'd2, 0, 16'h5555); step();
        op_valid = 0; load(0, 36'h0_DEAD_BEEF); step(); idle(); step();
        load(0, 36'h0_0000_0042); issue_op(3'd0, 1, 1, 1, 2'd0, 0, '0); step(); idle(); step();
        // R11: illegal opcodes
        cur_req = "R11";
        issue_op(3'd6, 0, 1, 0, 2'd0, 0, '0); step();
        issue_op(3'd5, 0, 1, 1, 2'd2, 0, 16'h1111); step(); idle(); step();

        // R12: high then low immediate equals one 32-bit immediate
        cur_req = "R12";
        base = 36'hF_8123_4567;
        load(0, base); step(); load(1, base); step(); idle();
        issue_op(3'd0, 0, 0, 0, 2'd2, 0, 16'h89AB); step(); idle(); step();
        issue_op(3'd0, 0, 0, 0, 2'd3, 0, 16'hCDEF); step(); idle(); step();
        exp_sum = longint'($signed(base)) + longint'($signed(32'h89AB_CDEF));
        rd_sel = 0; #1; chk("add32", rd_data, exp_sum[35:0]);
        issue_op(3'd2, 1, 0, 1, 2'd2, 0, 16'h89AB); step(); idle(); step();
        issue_op(3'd2, 1, 0, 1, 2'd3, 0, 16'hCDEF); step(); idle(); step();
        rd_sel = 1; #1; chk("and32", rd_data, base & {{4{1'b1}}, 32'h89AB_CDEF});

        // mixed random traffic, all requirements judged by the model
        cur_req = "R1-mix";
        for (int i = 0; i < 3000; i++) begin
            op_valid = ($urandom % 10) < 7;
            op_code  = 3'($urandom % 8);
            op_src   = 1'($urandom); op_tsel = 1'($urandom); op_dst = 1'($urandom);
            op_bsrc  = 2'($urandom); op_cmp = ($urandom % 5) == 0;
            op_imm   = 16'($urandom); prod = $urandom;
            ld_en    = ($urandom % 5) == 0; ld_sel = 1'($urandom);
            case ($urandom % 4)
                0: ld_data = 36'h7_FFFF_FFFF;
                1: ld_data = 36'h8_0000_0000;
                default: ld_data = {4'($urandom), 32'($urandom)};
            endcase
            step();
        end
        idle(); step();

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++; miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule